// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how long a cooling fan takes to turn once. It samples the fan's open-collector tachometer line, which gives two pulses for each revolution. It counts ticks of a fixed timebase from one rising edge to the rising edge two pulses later. The timebase is nominally 90 kHz, derived from the system clock. The resulting count is an unsigned reading in which a larger number means a slower fan. The reading is published to a byte-wide, read-only register port.

Three reserved codes sit at the top of the range:

- The all-ones code means the fan is stopped. It covers a stalled fan, an unconnected input and a count that ran out of range.
- The code one below all-ones means the fan is turning but is too slow to measure. It is used only when the slow option input is set.
- Every real measurement is at or below the code two below all-ones.

A host reads the reading one byte at a time. The first byte read of a pair freezes its partner, so the two halves always come from the same published value.

Top module: `fan_period_meter`

## Requirements
- R1: The count advances once per timebase tick. A tick comes every CLK_HZ/TICK_HZ system clock cycles, free running from reset, so the reading equals revolution time divided by the tick period.
- R2: One measurement covers two consecutive tachometer intervals. The published reading is the number of ticks that fall after the rising edge that starts a revolution, up to and including the cycle of the rising edge two pulses later. The tach input is asynchronous and passes through a two-stage synchronizer.
- R3: A completed revolution whose count is at most all-ones minus 2 (FFFDh for 16 bits) is published unchanged, so a slower fan gives a larger reading.
- R4: After reset the reading is all-ones (FFFFh) and rd_data is 00h.
- R5: If TIMEOUT_TICKS ticks pass with no rising edge, the reading becomes FFFFh. A new value is then published only after two further full intervals have been seen.
- R6: While edges keep arriving, a revolution count that passes FFFDh publishes the saturation code. That code is FFFEh when slow_en is 1 and FFFFh when slow_en is 0. It is published at the tick where the count passes FFFDh, and again at the end of that revolution.
- R7: A read is a one-cycle rd_en pulse. rd_sel = 0 selects the low byte (bits 7:0) and rd_sel = 1 selects the high byte (bits 15:8). rd_data carries the byte from the clock edge that samples rd_en, and holds it until the next read.
- R8: Reading the low byte first freezes the high byte. A later high-byte read returns the high byte of the value seen at the low-byte read, even if the reading was updated in between.
- R9: Reading the high byte first freezes the low byte in the same way. The following low-byte read returns the frozen low byte.
- R10: Between updates the reading holds its last value. It does not drift while the fan turns slower than the timeout allows to be noticed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_i | input | 1 | Raw tachometer input, asynchronous |
| slow_en | input | 1 | Selects FFFEh instead of FFFFh for a turning but unmeasurably slow fan |
| rd_en | input | 1 | One-cycle byte read strobe |
| rd_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
The hardest state to reach from the ports is a counter passing FFFDh while the tach edges keep coming. Edges must arrive often enough to stay inside the stall window, yet a whole revolution must span more than 65533 ticks. The bench runs the tick at the system clock rate and shortens the stall window to 36000 ticks. It then places rising edges 34000 cycles apart, reads FFFEh once the count has passed the limit, and clears slow_en before the closing edge so that the end of the revolution must report FFFFh. The coherence cases are set up by changing the fan period between the two byte reads.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

   typedef enum logic {
      BYTE_LO = 1'b0,
      BYTE_HI = 1'b1
   } byte_sel_e;

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tach_i,
   output logic rise_o
);

   // STAGES synchronizer flops plus one history flop for the edge compare
   logic [STAGES:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-1:0], tach_i};
   end

   assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];

   // R2: a synchronized rising edge is a single-cycle event
   a_r2_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int DIV = 2222
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             phase <= '0;
      else if (phase == LAST) phase <= '0;
      else                    phase <= phase + 1'b1;
   end

   assign tick_o = (phase == LAST);

   generate
      if (DIV > 1) begin : g_divided
         // R1: with a real divider, ticks never come back to back
         a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end else begin : g_passthru
         // R1: a divide-by-one timebase ticks every cycle
         a_r1_tick_every: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o);
      end
   endgenerate

endmodule

// File: rtl/period_counter.sv
module period_counter #(
   parameter int CNT_W         = 16,
   parameter int TIMEOUT_TICKS = 90000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rise,
   input  logic             slow_en,
   output logic [CNT_W-1:0] value_o
);

   localparam int IW = $clog2(TIMEOUT_TICKS + 1);
   localparam logic [CNT_W-1:0] STOP_CODE = '1;
   localparam logic [CNT_W-1:0] SLOW_CODE = {{(CNT_W-1){1'b1}}, 1'b0};
   localparam logic [CNT_W-1:0] MAX_REAL  = {{(CNT_W-2){1'b1}}, 2'b01};
   localparam logic [IW-1:0]    TMO       = IW'(TIMEOUT_TICKS);
   localparam logic [IW-1:0]    TMO_M1    = IW'(TIMEOUT_TICKS - 1);

   logic             armed;     // a revolution start edge has been seen
   logic             half;      // the middle edge of the revolution has been seen
   logic [CNT_W-1:0] rev_cnt;
   logic [IW-1:0]    idle_cnt;

   logic [CNT_W-1:0] rev_inc;
   logic [IW-1:0]    idle_inc;
   logic [CNT_W-1:0] sat_code;
   logic             rev_end, stall, sat_hit;

   always_comb begin
      rev_inc  = (tick && rev_cnt != STOP_CODE) ? rev_cnt + 1'b1 : rev_cnt;
      idle_inc = (tick && idle_cnt != TMO) ? idle_cnt + 1'b1 : idle_cnt;
      sat_code = slow_en ? SLOW_CODE : STOP_CODE;
      rev_end  = rise && armed && half;
      stall    = !rise && tick && idle_cnt == TMO_M1;
      sat_hit  = armed && tick && rev_cnt == MAX_REAL && !rev_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         half     <= 1'b0;
         rev_cnt  <= '0;
         idle_cnt <= '0;
         value_o  <= STOP_CODE;
      end else begin
         idle_cnt <= rise ? '0 : idle_inc;
         if (rise) begin
            if (!armed) begin
               armed   <= 1'b1;
               half    <= 1'b0;
               rev_cnt <= '0;
            end else if (!half) begin
               half    <= 1'b1;
               rev_cnt <= rev_inc;
            end else begin
               half    <= 1'b0;
               rev_cnt <= '0;
               value_o <= (rev_inc > MAX_REAL) ? sat_code : rev_inc;
            end
         end else if (stall) begin
            armed   <= 1'b0;
            half    <= 1'b0;
            rev_cnt <= '0;
            value_o <= STOP_CODE;
         end else begin
            if (armed)   rev_cnt <= rev_inc;
            if (sat_hit) value_o <= sat_code;
         end
      end
   end

   // R3: an in-range revolution is published exactly as counted
   a_r3_value_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_end && rev_inc <= MAX_REAL) |=> value_o == $past(rev_inc));

   // R6: the slow code appears only when the option was set
   a_r6_slow_code_needs_option: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(value_o) && value_o == SLOW_CODE) |-> $past(slow_en));

   // R10: the reading changes only on a tick or a tach edge
   a_r10_hold_between_events: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value_o) |-> $past(tick || rise));

   // R5: the silence counter never runs past the stall window
   always_comb begin
      if (rst_n) a_r5_idle_bound: assert (idle_cnt <= TMO);
   end

endmodule

// File: rtl/byte_readout.sv
module byte_readout
   import fan_tach_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*BYTE_W-1:0] value_i,
   input  logic                rd_en,
   input  logic                rd_sel,
   output logic [BYTE_W-1:0]   rd_data
);

   logic [2*BYTE_W-1:0] snap;
   logic                pend;
   byte_sel_e           pend_sel;
   byte_sel_e           sel;
   logic                take_frozen;

   function automatic logic [BYTE_W-1:0] pick(input logic [2*BYTE_W-1:0] w,
                                              input byte_sel_e s);
      return (s == BYTE_HI) ? w[2*BYTE_W-1:BYTE_W] : w[BYTE_W-1:0];
   endfunction

   assign sel         = byte_sel_e'(rd_sel);
   assign take_frozen = pend && (sel == pend_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap     <= '0;
         pend     <= 1'b0;
         pend_sel <= BYTE_LO;
         rd_data  <= '0;
      end else if (rd_en) begin
         if (take_frozen) begin
            rd_data <= pick(snap, sel);
            pend    <= 1'b0;
         end else begin
            rd_data  <= pick(value_i, sel);
            snap     <= value_i;
            pend     <= 1'b1;
            pend_sel <= byte_sel_e'(~rd_sel);
         end
      end
   end

   // R8, R9: the frozen partner byte does not move while waiting to be read
   a_r8_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !rd_en) |=> ($stable(snap) && $stable(pend_sel) && pend));

   // R9: reading the frozen byte closes the pair
   a_r9_pair_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && take_frozen) |=> !pend);

   // R7: rd_data only changes in answer to a read
   a_r7_data_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> $past(rd_en));

endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter #(
   parameter int CLK_HZ        = 200_000_000,
   parameter int TICK_HZ       = 90_000,
   parameter int BYTE_W        = 8,
   parameter int CNT_W         = 16,
   parameter int TIMEOUT_TICKS = 90_000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tach_i,
   input  logic              slow_en,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int DIV = CLK_HZ / TICK_HZ;

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("count width must be exactly two bytes");
      end
      if (DIV < 1) begin : g_bad_div
         $error("system clock must be at least the tick rate");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs at least two stages");
      end
      if (TIMEOUT_TICKS < 2) begin : g_bad_tmo
         $error("stall window must be at least two ticks");
      end
   endgenerate

   logic             rise;
   logic             tick;
   logic [CNT_W-1:0] reading;

   tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tach_i (tach_i),
      .rise_o (rise)
   );

   tick_prescaler #(.DIV(DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   period_counter #(
      .CNT_W         (CNT_W),
      .TIMEOUT_TICKS (TIMEOUT_TICKS)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rise    (rise),
      .slow_en (slow_en),
      .value_o (reading)
   );

   byte_readout #(.BYTE_W(BYTE_W)) u_read (
      .clk     (clk),
      .rst_n   (rst_n),
      .value_i (reading),
      .rd_en   (rd_en),
      .rd_sel  (rd_sel),
      .rd_data (rd_data)
   );

endmodule

// File: tb/fan_period_meter_test.sv
`timescale 1ns/1ps
module fan_period_meter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tach = 1'b0;
   logic       slow_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] rd_data3;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   // tick every cycle, short stall window
   fan_period_meter #(
      .CLK_HZ(90000), .TICK_HZ(90000), .TIMEOUT_TICKS(36000)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tach_i(tach), .slow_en(slow_en),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   // tick every third cycle, exercises the divider
   fan_period_meter #(
      .CLK_HZ(270000), .TICK_HZ(90000), .TIMEOUT_TICKS(36000)
   ) uut3 (
      .clk(clk), .rst_n(rst_n), .tach_i(tach), .slow_en(slow_en),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data3)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_byte(input logic sel, output logic [7:0] b, output logic [7:0] b3);
      @(negedge clk);
      rd_en  = 1'b1;
      rd_sel = sel;
      @(negedge clk);
      rd_en  = 1'b0;
      b  = rd_data;
      b3 = rd_data3;
   endtask

   task automatic read_word(output logic [15:0] w, output logic [15:0] w3);
      logic [7:0] lo, hi, lo3, hi3;
      rd_byte(1'b0, lo, lo3);
      rd_byte(1'b1, hi, hi3);
      w  = {hi, lo};
      w3 = {hi3, lo3};
   endtask

   task automatic spin(input int period, input int n);
      for (int i = 0; i < n; i++) begin
         tach = 1'b1;
         repeat (period / 2) @(negedge clk);
         tach = 1'b0;
         repeat (period - period / 2) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [15:0] w, w3;
      check("R4 rd_data after reset", {8'h00, rd_data}, 16'h0000);
      read_word(w, w3);
      check("R4 reading after reset", w, 16'hFFFF);
   endtask

   task automatic t_basic();
      logic [15:0] w, w3;
      spin(150, 5);
      repeat (10) @(negedge clk);
      read_word(w, w3);
      check("R2 two intervals of 150 cycles", w, 16'd300);
      check("R1 divided tick, 300 cycles / 3", w3, 16'd100);
      // R7: same byte read returns live low byte when no pair is pending
      check("R7 byte order of reading", {8'h00, w[7:0]}, 16'h002C);
   endtask

   task automatic t_slower();
      logic [15:0] w, w3;
      spin(1603, 4);
      repeat (10) @(negedge clk);
      read_word(w, w3);
      check("R3 slow fan count 0C86h", w, 16'h0C86);
      check("R3 slower fan gives larger count", {15'd0, w > 16'd300}, 16'd1);
   endtask

   task automatic t_lo_first();
      logic [15:0] w, w3;
      logic [7:0]  b, b3;
      spin(200, 4);
      repeat (10) @(negedge clk);
      rd_byte(1'b0, b, b3);
      check("R7 low byte of 0190h", {8'h00, b}, 16'h0090);
      spin(700, 4);
      repeat (10) @(negedge clk);
      rd_byte(1'b1, b, b3);
      check("R8 frozen high byte after update", {8'h00, b}, 16'h0001);
      read_word(w, w3);
      check("R8 fresh pair after frozen read", w, 16'h0578);
   endtask

   task automatic t_hi_first();
      logic [15:0] w, w3;
      logic [7:0]  b, b3;
      rd_byte(1'b1, b, b3);
      check("R9 high byte of 0578h", {8'h00, b}, 16'h0005);
      spin(100, 4);
      repeat (10) @(negedge clk);
      rd_byte(1'b0, b, b3);
      check("R9 frozen low byte after update", {8'h00, b}, 16'h0078);
      read_word(w, w3);
      check("R9 fresh pair after frozen read", w, 16'h00C8);
   endtask

   task automatic t_timeout();
      logic [15:0] w, w3;
      spin(50, 4);
      repeat (34900) @(negedge clk);
      read_word(w, w3);
      check("R10 reading held inside stall window", w, 16'd100);
      repeat (1200) @(negedge clk);
      read_word(w, w3);
      check("R5 stall publishes FFFFh", w, 16'hFFFF);
      spin(50, 2);
      read_word(w, w3);
      check("R5 two edges after stall publish nothing", w, 16'hFFFF);
      // third edge comes 50 + 4 cycles after the second
      spin(50, 1);
      repeat (10) @(negedge clk);
      read_word(w, w3);
      check("R5 first revolution after stall", w, 16'd104);
   endtask

   task automatic t_saturate();
      logic [15:0] w, w3;
      repeat (36100) @(negedge clk);
      read_word(w, w3);
      check("R5 stall again before saturation case", w, 16'hFFFF);
      slow_en = 1'b1;
      spin(34000, 1);
      tach = 1'b1;
      repeat (32000) @(negedge clk);
      read_word(w, w3);
      check("R6 passing FFFDh with slow option gives FFFEh", w, 16'hFFFE);
      slow_en = 1'b0;
      tach = 1'b0;
      repeat (2000) @(negedge clk);
      tach = 1'b1;
      repeat (20) @(negedge clk);
      read_word(w, w3);
      check("R6 revolution end past FFFDh without option gives FFFFh", w, 16'hFFFF);
      tach = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_slower();
      t_lo_first();
      t_hi_first();
      t_timeout();
      t_saturate();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule